// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration port a host sees on its I/O side. It takes two byte-wide addresses: an index port and a data port one address above it. The host opens the port by writing a key byte to the index port and then works on one register at a time. It writes the register number to the index port and then reads or writes that register through the data port. A second key byte closes the port again. While the port is closed, every data-port access has no effect and every read returns all ones.

Behind the port sit a few registers. A logical-device selector chooses which device the per-device registers refer to. A fixed chip identifier can be read but not written. The embedded-controller logical device has an activation bit and a 16-bit base address. The base address is stored across two indices with the low byte at the lower index, which is the reverse of the usual ordering. The activation bit and the base address drive the rest of the system directly. A base address of zero marks the device as not yet placed, so the block reports it as inactive.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed, the index register and the logical-device selector are 0x00, `ec_enable` is 1 and `ec_base` equals the `RESET_BASE` parameter.
- R2: An index-port write of 0x55 while closed opens the port, and an index-port write of 0xAA while open closes it. Any other index-port write while closed changes nothing.
- R3: While the port is closed, data-port writes change no register, and any read of either port returns 0xFF.
- R4: A read strobe (`rd_en`) produces `rd_valid` high on the following cycle, with the read byte on `rd_data` in that same cycle. Without a strobe, `rd_valid` is low.
- R5: While open, an index-port read returns the last index byte written, and a byte other than the 0xAA key is stored as the index.
- R6: Index 0x07 is the logical-device selector, and it can be both written and read back through the data port.
- R7: Index 0x20 reads as 0xC6 when `ALT_ID` is 0 and as 0xC7 when it is 1, and writes to it are ignored.
- R8: When logical device 0x0C is selected, bit 0 at index 0x30 is the activation bit on `ec_enable`. It reads back as {7'b0, enable}, and the other written bits are dropped.
- R9: When device 0x0C is selected, index 0x66 holds `ec_base[7:0]` and index 0x67 holds `ec_base[15:8]`. Both can be written and read.
- R10: When any other device is selected, indices 0x30, 0x66 and 0x67 read 0x00 and writes to them are ignored.
- R11: `ec_active` is high only when `ec_enable` is 1 and `ec_base` is nonzero.
- R12: An index with no register behind it reads 0x00 through the data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid when rd_valid is high |
| rd_valid | output | 1 | High one cycle after rd_en |
| ec_enable | output | 1 | Activation bit of the embedded-controller device |
| ec_base | output | 16 | Base address of the embedded-controller device |
| ec_active | output | 1 | Device enabled and placed at a nonzero base |

## Verification
The checker checks several things on every cycle. It checks the key transitions, the read latency, and that a closed port reads all ones. It also checks that the outputs stay frozen while the port is closed, that the identifier reads correctly, that the index reads back, and that a zero base never reports active. The bench scenarios cover what depends on a sequence of accesses. These are the byte order of the base address, the masking of the activation bit, and the silence of the per-device registers when another device is selected. They also include a discarded write to the identifier, and the index surviving a close and reopen.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;

    localparam logic [7:0] KEY_OPEN    = 8'h55;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_CHIPID  = 8'h20;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_LO = 8'h66;
    localparam logic [7:0] IDX_BASE_HI = 8'h67;
    localparam logic [7:0] LDN_EC      = 8'h0C;
    localparam logic [7:0] CLOSED_READ = 8'hFF;

    typedef enum logic [1:0] {
        CFG_LOCKED = 2'b01,
        CFG_OPEN   = 2'b10
    } cfg_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LDN,
        SEL_CHIPID,
        SEL_ACT,
        SEL_BASE_LO,
        SEL_BASE_HI
    } reg_sel_e;

    typedef struct packed {
        logic        enable;
        logic [15:0] base;
    } ldev_cfg_t;

    function automatic reg_sel_e decode_index(input logic [7:0] idx);
        reg_sel_e s;
        case (idx)
            IDX_LDN:     s = SEL_LDN;
            IDX_CHIPID:  s = SEL_CHIPID;
            IDX_ACT:     s = SEL_ACT;
            IDX_BASE_LO: s = SEL_BASE_LO;
            IDX_BASE_HI: s = SEL_BASE_HI;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] chip_id(input logic alt);
        return alt ? 8'hC7 : 8'hC6;
    endfunction

endpackage

// File: rtl/sio_key_gate.sv
`timescale 1ns/1ps
module sio_key_gate
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wr_data,
    output logic       cfg_open,
    output logic [7:0] idx_q
);

    cfg_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CFG_LOCKED;
            idx_q   <= 8'h00;
        end else if (idx_wr) begin
            case (state_q)
                CFG_LOCKED: begin
                    if (wr_data == KEY_OPEN) state_q <= CFG_OPEN;
                end
                CFG_OPEN: begin
                    if (wr_data == KEY_CLOSE) state_q <= CFG_LOCKED;
                    else                      idx_q   <= wr_data;
                end
                default: state_q <= CFG_LOCKED;
            endcase
        end
    end

    assign cfg_open = (state_q == CFG_OPEN);

endmodule

// File: rtl/sio_ldev_bank.sv
`timescale 1ns/1ps
module sio_ldev_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] RESET_BASE = 16'h0A00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_wr,
    input  reg_sel_e   sel,
    input  logic [7:0] wr_data,
    output logic [7:0] ldn_q,
    output logic       ec_sel,
    output ldev_cfg_t  ec_cfg,
    output logic       ec_active
);

    ldev_cfg_t cfg_q;

    assign ec_sel = (ldn_q == LDN_EC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ldn_q        <= 8'h00;
            cfg_q.enable <= 1'b1;
            cfg_q.base   <= RESET_BASE;
        end else if (data_wr) begin
            case (sel)
                SEL_LDN:     ldn_q <= wr_data;
                SEL_ACT:     if (ec_sel) cfg_q.enable     <= wr_data[0];
                SEL_BASE_LO: if (ec_sel) cfg_q.base[7:0]  <= wr_data;
                SEL_BASE_HI: if (ec_sel) cfg_q.base[15:8] <= wr_data;
                default: ;
            endcase
        end
    end

    assign ec_cfg    = cfg_q;
    assign ec_active = cfg_q.enable && (cfg_q.base != 16'h0000);

endmodule

// File: rtl/sio_read_mux.sv
`timescale 1ns/1ps
module sio_read_mux
    import sio_cfg_pkg::*;
#(
    parameter bit ALT_ID = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       port_sel,
    input  logic       cfg_open,
    input  logic [7:0] idx_q,
    input  reg_sel_e   sel,
    input  logic [7:0] ldn_q,
    input  logic       ec_sel,
    input  ldev_cfg_t  ec_cfg,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    logic [7:0] id_byte;
    logic [7:0] data_byte;
    logic [7:0] next_byte;

    generate
        if (ALT_ID) begin : g_id_alt
            assign id_byte = chip_id(1'b1);
        end else begin : g_id_base
            assign id_byte = chip_id(1'b0);
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_LDN:     data_byte = ldn_q;
            SEL_CHIPID:  data_byte = id_byte;
            SEL_ACT:     data_byte = ec_sel ? {7'b0, ec_cfg.enable} : 8'h00;
            SEL_BASE_LO: data_byte = ec_sel ? ec_cfg.base[7:0]  : 8'h00;
            SEL_BASE_HI: data_byte = ec_sel ? ec_cfg.base[15:8] : 8'h00;
            default:     data_byte = 8'h00;
        endcase
    end

    always_comb begin
        if (!cfg_open)      next_byte = CLOSED_READ;
        else if (!port_sel) next_byte = idx_q;
        else                next_byte = data_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= next_byte;
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter bit          ALT_ID     = 1'b0,
    parameter logic [15:0] RESET_BASE = 16'h0A00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        port_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        ec_enable,
    output logic [15:0] ec_base,
    output logic        ec_active
);

    logic       cfg_open;
    logic [7:0] cfg_idx;
    logic [7:0] cur_ldn;
    logic       ec_sel;
    reg_sel_e   cur_sel;
    ldev_cfg_t  ec_cfg;

    assign cur_sel = decode_index(cfg_idx);

    sio_key_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (wr_en && !port_sel),
        .wr_data  (wr_data),
        .cfg_open (cfg_open),
        .idx_q    (cfg_idx)
    );

    sio_ldev_bank #(.RESET_BASE(RESET_BASE)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .data_wr   (wr_en && port_sel && cfg_open),
        .sel       (cur_sel),
        .wr_data   (wr_data),
        .ldn_q     (cur_ldn),
        .ec_sel    (ec_sel),
        .ec_cfg    (ec_cfg),
        .ec_active (ec_active)
    );

    sio_read_mux #(.ALT_ID(ALT_ID)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .port_sel (port_sel),
        .cfg_open (cfg_open),
        .idx_q    (cfg_idx),
        .sel      (cur_sel),
        .ldn_q    (cur_ldn),
        .ec_sel   (ec_sel),
        .ec_cfg   (ec_cfg),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign ec_enable = ec_cfg.enable;
    assign ec_base   = ec_cfg.base;

endmodule

// File: rtl/sio_cfg_port_chk.sv
`timescale 1ns/1ps
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter bit ALT_ID = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic        port_sel,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        ec_enable,
    input logic [15:0] ec_base,
    input logic        ec_active,
    input logic        cfg_open,
    input logic [7:0]  cfg_idx
);

    localparam logic [7:0] EXP_ID = ALT_ID ? 8'hC7 : 8'hC6;

    AST_RD_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R4
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R4
    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cfg_open) |=> (rd_data == CLOSED_READ)); // R3
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> ($stable(ec_base) && $stable(ec_enable))); // R3
    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && wr_en && !port_sel && wr_data == KEY_OPEN) |=> cfg_open); // R2
    AST_LOCK_KEY: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && wr_en && !port_sel && wr_data == KEY_CLOSE) |=> !cfg_open); // R2
    AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && rd_en && port_sel && cfg_idx == IDX_CHIPID) |=> (rd_data == EXP_ID)); // R7
    AST_IDX_READ: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && rd_en && !port_sel) |=> (rd_data == $past(cfg_idx))); // R5
    AST_ZERO_BASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ec_base == 16'h0000) |-> !ec_active); // R11
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ec_enable |-> !ec_active); // R11

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ALT_ID(ALT_ID)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .ec_enable (ec_enable),
    .ec_base   (ec_base),
    .ec_active (ec_active),
    .cfg_open  (cfg_open),
    .cfg_idx   (cfg_idx)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;

    localparam logic [15:0] RB = 16'h0A00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        ec_enable;
    logic [15:0] ec_base;
    logic        ec_active;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sio_cfg_port #(.ALT_ID(1'b0), .RESET_BASE(RB)) u_sio_cfg_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ec_enable(ec_enable), .ec_base(ec_base), .ec_active(ec_active)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_sel = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic p, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; port_sel = p;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever the design presents a read byte
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 enable", {31'h0, ec_enable}, 32'd1);
        check("R1 base", {16'h0, ec_base}, {16'h0, RB});
        check("R11 active at reset", {31'h0, ec_active}, 32'd1);
        // R3 closed port
        rd(1'b0, 8'hFF, "R3 index read closed");
        rd(1'b1, 8'hFF, "R3 data read closed");
        wr(1'b0, 8'h66);          // R2 ignored while closed
        wr(1'b1, 8'h12);          // R3 data write ignored
        check("R3 base held", {16'h0, ec_base}, {16'h0, RB});
        // R2 open
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h00, "R2 index not taken while closed");
        // R7 chip id
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h20, "R5 index readback");
        rd(1'b1, 8'hC6, "R7 chip id");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'hC6, "R7 id write ignored");
        // R1/R10 with device 0 selected
        wr(1'b0, 8'h07);
        rd(1'b1, 8'h00, "R1 ldn reset");
        wr(1'b0, 8'h30);
        rd(1'b1, 8'h00, "R10 act reads zero");
        wr(1'b1, 8'h00);
        check("R10 enable unchanged", {31'h0, ec_enable}, 32'd1);
        wr(1'b0, 8'h66);
        wr(1'b1, 8'h99);
        rd(1'b1, 8'h00, "R10 base lo reads zero");
        check("R10 base unchanged", {16'h0, ec_base}, {16'h0, RB});
        // R6 select embedded controller
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h0C);
        rd(1'b1, 8'h0C, "R6 ldn readback");
        // R8 activation bit
        wr(1'b0, 8'h30);
        rd(1'b1, 8'h01, "R8 act read");
        wr(1'b1, 8'hFE);
        check("R8 enable cleared", {31'h0, ec_enable}, 32'd0);
        check("R11 inactive when disabled", {31'h0, ec_active}, 32'd0);
        rd(1'b1, 8'h00, "R8 masked bits");
        wr(1'b1, 8'h01);
        check("R8 enable set", {31'h0, ec_enable}, 32'd1);
        // R9 base byte order
        wr(1'b0, 8'h66);
        wr(1'b1, 8'h34);
        check("R9 low byte", {16'h0, ec_base}, 32'h0A34);
        wr(1'b0, 8'h67);
        wr(1'b1, 8'h12);
        check("R9 high byte", {16'h0, ec_base}, 32'h1234);
        rd(1'b1, 8'h12, "R9 hi read");
        wr(1'b0, 8'h66);
        rd(1'b1, 8'h34, "R9 lo read");
        // R11 zero base
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h67);
        wr(1'b1, 8'h00);
        check("R11 zero base inactive", {31'h0, ec_active}, 32'd0);
        check("R11 enable still set", {31'h0, ec_enable}, 32'd1);
        // R12 unimplemented index
        wr(1'b0, 8'h40);
        rd(1'b1, 8'h00, "R12 unimplemented");
        wr(1'b0, 8'h67);
        // R2 close, R3 writes dropped
        wr(1'b0, 8'hAA);
        rd(1'b1, 8'hFF, "R2 closed after key");
        wr(1'b1, 8'h77);
        check("R3 base held after close", {16'h0, ec_base}, 32'h0000);
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h67, "R5 index kept across close");
        rd(1'b1, 8'h00, "R3 closed write dropped");
        repeat (3) @(negedge clk);
        check("R4 scoreboard drained", exp_q.size(), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule